// File: doc/BRIEF.md
# Rotating Windowed Register Mapper

This block turns a 7-bit logical integer register number into the physical index of a 128-entry register file. The lowest 32 numbers are global and pass through unchanged. Every higher number names a slot in the current procedure frame. That frame sits at a moving base inside a 96-entry circular stacked region, and a wrap of the region's end goes back to physical index 32.

Software first sizes the frame with an allocate operation: a total frame size, a local-area size and a rotating-area size. A call moves the base forward by the caller's local size, so the caller's output area becomes the bottom of the callee's frame. The call also saves the caller's frame descriptor on an internal stack 8 entries deep. A return restores the saved descriptor. A rotate pulse steps the rotation base back by one, modulo the rotating-area size, which renames the rotating registers for software-pipelined loops.

Translation is combinational from the current frame state. Operations take effect at the next clock edge. Errors in calls, returns and allocates raise a one-cycle registered overflow or underflow flag.

Top module: `reg_window_mapper`

## Requirements
- R1: A logical index below 32 gives `preg` equal to `lreg` with `illegal` low, whatever the frame state.
- R2: For a stacked index `lreg` >= 32 outside the rotating area with offset d = `lreg`-32 below the frame size, `preg` = 32 + ((base + d) mod 96).
- R3: A stacked index whose offset d is at least the current frame size raises `illegal` and drives `preg` to 0.
- R4: An allocate loads frame size, local size and rotating size from the next edge on and clears the rotation base. It is refused, with state unchanged and `overflow` high for the following cycle, if frame > 96, local > frame, rotating > frame, or rotating is not a multiple of 8.
- R5: A call with fewer than 8 saved frames sets base to (base + local) mod 96 and frame size to frame − local. Local size, rotating size and rotation base become 0. Caller offset local+k is then reached as callee offset k.
- R6: A return with at least one saved frame restores base, frame, local and rotating sizes and the rotation base saved by the matching call.
- R7: A call with 8 frames saved changes no state and raises `overflow` for one cycle.
- R8: A return with no saved frame changes no state and raises `underflow` for one cycle.
- R9: A rotate sets the rotation base r to (r − 1) mod S, where S is the rotating size. An offset d < S is first remapped to (d + r) mod S before the base is added. With S = 0, rotate has no effect.
- R10: Only one operation acts per cycle, by priority allocate > call > return > rotate. Lower-priority requests in the same cycle are ignored.
- R11: After reset, base, all sizes and the rotation base are 0, the save stack is empty, both flags are low, and every stacked index is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_frame | input | 7 | Requested frame size |
| alloc_local | input | 7 | Requested local-area size |
| alloc_rot | input | 7 | Requested rotating-area size |
| call_valid | input | 1 | Call request |
| ret_valid | input | 1 | Return request |
| rotate | input | 1 | Rotation step request |
| lreg | input | 7 | Logical register index |
| preg | output | 7 | Physical register index |
| illegal | output | 1 | Index lies beyond the current frame |
| overflow | output | 1 | Refused allocate or call, one cycle |
| underflow | output | 1 | Return with nothing saved, one cycle |

## Verification
Some properties are checked by assertions on every cycle. The save stack is never pushed when full or popped when empty, and a push never coincides with a pop. The rotation base stays below the rotating size, and the frame always fits the region. Every accepted call moves the base by exactly the old local size, and a failed call or return raises its flag while freezing the base. Only the bench scenarios can show that the mapping is correct for specific indices. That covers wraparound past the region end, rotated remapping, the full restore on return, the priority of simultaneous requests, and a stack filled to 8 and emptied again.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [2:0] {
    WM_NOP,
    WM_ALLOC,
    WM_CALL,
    WM_RET,
    WM_ROT
  } wm_op_e;

  // Single-operation decode with fixed priority: alloc > call > ret > rotate
  function automatic wm_op_e wm_decode(input logic a, input logic c,
                                       input logic r, input logic t);
    if (a)      return WM_ALLOC;
    else if (c) return WM_CALL;
    else if (r) return WM_RET;
    else if (t) return WM_ROT;
    else        return WM_NOP;
  endfunction
endpackage

// File: rtl/wm_desc_stack.sv
module wm_desc_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] top_idx;

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[cnt[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + 1'b1;
    else if (pop)  cnt <= cnt - 1'b1;
  end

  assign top_idx = cnt - 1'b1;
  assign dout    = mem[top_idx[AW-1:0]];
  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);

  AST_NO_PUSH_FULL:  assert property (@(posedge clk) disable iff (rst) full |-> !push);   // R7
  AST_NO_POP_EMPTY:  assert property (@(posedge clk) disable iff (rst) empty |-> !pop);  // R8
  AST_ONE_STACK_OP:  assert property (@(posedge clk) disable iff (rst) !(push && pop));  // R10
endmodule

// File: rtl/wm_xlate.sv
module wm_xlate #(
  parameter int NREG  = 128,
  parameter int NGLOB = 32,
  parameter int IW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] lreg,
  input  logic [IW-1:0] base,
  input  logic [IW-1:0] sof,
  input  logic [IW-1:0] sor,
  input  logic [IW-1:0] rrb,
  output logic [IW-1:0] preg,
  output logic          illegal
);
  localparam int NSTK = NREG - NGLOB;

  logic [IW:0] off, roff, sum;

  always_comb begin
    off  = {1'b0, lreg} - (IW+1)'(NGLOB);
    roff = off;
    if (off < {1'b0, sor}) begin
      roff = off + {1'b0, rrb};
      if (roff >= {1'b0, sor}) roff = roff - {1'b0, sor};
    end
    sum = roff + {1'b0, base};
    if (sum >= (IW+1)'(NSTK)) sum = sum - (IW+1)'(NSTK);

    if (lreg < IW'(NGLOB)) begin
      preg    = lreg;
      illegal = 1'b0;
    end else if (off >= {1'b0, sof}) begin
      preg    = '0;
      illegal = 1'b1;
    end else begin
      preg    = IW'(sum + (IW+1)'(NGLOB));
      illegal = 1'b0;
    end
  end

  AST_STACKED_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (!illegal && lreg >= IW'(NGLOB)) |-> (preg >= IW'(NGLOB)));                          // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (preg == '0 && lreg >= IW'(NGLOB)));                                     // R3
endmodule

// File: rtl/reg_window_mapper.sv
module reg_window_mapper #(
  parameter int NREG      = 128,
  parameter int NGLOB     = 32,
  parameter int STK_DEPTH = 8,
  parameter int ROT_GRAIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_valid,
  input  logic [$clog2(NREG)-1:0] alloc_frame,
  input  logic [$clog2(NREG)-1:0] alloc_local,
  input  logic [$clog2(NREG)-1:0] alloc_rot,
  input  logic                    call_valid,
  input  logic                    ret_valid,
  input  logic                    rotate,
  input  logic [$clog2(NREG)-1:0] lreg,
  output logic [$clog2(NREG)-1:0] preg,
  output logic                    illegal,
  output logic                    overflow,
  output logic                    underflow
);
  import wm_pkg::*;

  localparam int IW   = $clog2(NREG);
  localparam int NSTK = NREG - NGLOB;
  localparam int DW   = 5 * IW;

  logic [IW-1:0] base, sof, sol, sor, rrb;
  logic          ovf_q, udf_q;
  wm_op_e        op;
  logic          alloc_bad, push, pop, st_full, st_empty;
  logic [DW-1:0] st_din, st_dout;
  logic [IW:0]   nbase;

  assign op = wm_decode(alloc_valid, call_valid, ret_valid, rotate);

  assign alloc_bad = (alloc_frame > IW'(NSTK)) || (alloc_local > alloc_frame) ||
                     (alloc_rot > alloc_frame) || ((int'(alloc_rot) % ROT_GRAIN) != 0);

  assign push   = (op == WM_CALL) && !st_full;
  assign pop    = (op == WM_RET)  && !st_empty;
  assign st_din = {base, sof, sol, sor, rrb};

  always_comb begin
    nbase = {1'b0, base} + {1'b0, sol};
    if (nbase >= (IW+1)'(NSTK)) nbase = nbase - (IW+1)'(NSTK);
  end

  wm_desc_stack #(.DEPTH(STK_DEPTH), .DW(DW)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .din   (st_din),
    .dout  (st_dout),
    .full  (st_full),
    .empty (st_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= '0;
      sof   <= '0;
      sol   <= '0;
      sor   <= '0;
      rrb   <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ((op == WM_ALLOC) && alloc_bad) || ((op == WM_CALL) && st_full);
      udf_q <= (op == WM_RET) && st_empty;
      if ((op == WM_ALLOC) && !alloc_bad) begin
        sof <= alloc_frame;
        sol <= alloc_local;
        sor <= alloc_rot;
        rrb <= '0;
      end else if (push) begin
        base <= nbase[IW-1:0];
        sof  <= sof - sol;
        sol  <= '0;
        sor  <= '0;
        rrb  <= '0;
      end else if (pop) begin
        {base, sof, sol, sor, rrb} <= st_dout;
      end else if ((op == WM_ROT) && (sor != '0)) begin
        rrb <= (rrb == '0) ? (sor - 1'b1) : (rrb - 1'b1);
      end
    end
  end

  wm_xlate #(.NREG(NREG), .NGLOB(NGLOB), .IW(IW)) u_xlate (
    .clk     (clk),
    .rst     (rst),
    .lreg    (lreg),
    .base    (base),
    .sof     (sof),
    .sor     (sor),
    .rrb     (rrb),
    .preg    (preg),
    .illegal (illegal)
  );

  assign overflow  = ovf_q;
  assign underflow = udf_q;

  AST_CALL_SHIFT: assert property (@(posedge clk) disable iff (rst)
    push |=> (int'(base) == (int'($past(base)) + int'($past(sol))) % NSTK));            // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op == WM_CALL && st_full) |=> (overflow && $stable(base) && $stable(sof)));         // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op == WM_RET && st_empty) |=> (underflow && $stable(base) && $stable(sof)));        // R8
  AST_ROT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (sor != '0) |-> (rrb < sor));                                                        // R9
  AST_FRAME_FITS: assert property (@(posedge clk) disable iff (rst)
    (sof <= IW'(NSTK)) && (sol <= sof) && (sor <= sof));                                 // R4
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(overflow && underflow));                                                           // R10
endmodule

// File: tb/tb_reg_window_mapper.sv
`timescale 1ns/1ps
module tb_reg_window_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_valid = 0, call_valid = 0, ret_valid = 0, rotate = 0;
  logic [6:0] alloc_frame = 0, alloc_local = 0, alloc_rot = 0, lreg = 0;
  logic [6:0] preg;
  logic       illegal, overflow, underflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  reg_window_mapper dut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_frame(alloc_frame),
    .alloc_local(alloc_local), .alloc_rot(alloc_rot), .call_valid(call_valid),
    .ret_valid(ret_valid), .rotate(rotate), .lreg(lreg), .preg(preg),
    .illegal(illegal), .overflow(overflow), .underflow(underflow)
  );

  // reference model of the frame state
  int m_base = 0, m_sof = 0, m_sol = 0, m_sor = 0, m_rrb = 0, m_cnt = 0;
  int s_base[8], s_sof[8], s_sol[8], s_sor[8], s_rrb[8];

  typedef struct { int l; int p; bit ill; string req; } item_t;
  item_t q[$];

  function automatic void model_map(input int l, output int p, output bit ill);
    int d;
    if (l < 32) begin p = l; ill = 0; return; end
    d = l - 32;
    if (d >= m_sof) begin p = 0; ill = 1; return; end
    if (d < m_sor) d = (d + m_rrb) % m_sor;
    p = 32 + (m_base + d) % 96;
    ill = 0;
  endfunction

  // monitor: one expected item per cycle, compared mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (preg !== it.p[6:0] || illegal !== it.ill) begin
          errors++;
          $display("FAIL %s lreg=%0d actual preg=%0d illegal=%0d expected preg=%0d illegal=%0d",
                   it.req, it.l, preg, illegal, it.p, it.ill);
        end
      end
    end
  end

  task automatic drive_map(input int l, input int p, input bit ill, input string req);
    item_t it;
    @(posedge clk); #1;
    lreg = l[6:0];
    it.l = l; it.p = p; it.ill = ill; it.req = req;
    q.push_back(it);
  endtask

  task automatic probe(input string req);
    int lst[12] = '{0, 31, 32, 33, 38, 39, 40, 45, 51, 52, 63, 127};
    foreach (lst[i]) begin
      int p; bit ill;
      model_map(lst[i], p, ill);
      drive_map(lst[i], p, ill, req);
    end
    wait (q.size() == 0);
  endtask

  task automatic chk_flags(input bit eo, input bit eu, input string req);
    checks++;
    if (overflow !== eo || underflow !== eu) begin
      errors++;
      $display("FAIL %s actual ovf=%0d udf=%0d expected ovf=%0d udf=%0d",
               req, overflow, underflow, eo, eu);
    end
  endtask

  task automatic do_op(input bit a, input int f, input int l, input int r,
                       input bit c, input bit rt, input bit ro, input string req);
    bit eo = 0, eu = 0;
    @(posedge clk); #1;
    alloc_valid = a; alloc_frame = f[6:0]; alloc_local = l[6:0]; alloc_rot = r[6:0];
    call_valid = c; ret_valid = rt; rotate = ro;
    if (a) begin
      if (f > 96 || l > f || r > f || (r % 8) != 0) eo = 1;
      else begin m_sof = f; m_sol = l; m_sor = r; m_rrb = 0; end
    end else if (c) begin
      if (m_cnt == 8) eo = 1;
      else begin
        s_base[m_cnt] = m_base; s_sof[m_cnt] = m_sof; s_sol[m_cnt] = m_sol;
        s_sor[m_cnt] = m_sor; s_rrb[m_cnt] = m_rrb; m_cnt++;
        m_base = (m_base + m_sol) % 96; m_sof = m_sof - m_sol;
        m_sol = 0; m_sor = 0; m_rrb = 0;
      end
    end else if (rt) begin
      if (m_cnt == 0) eu = 1;
      else begin
        m_cnt--;
        m_base = s_base[m_cnt]; m_sof = s_sof[m_cnt]; m_sol = s_sol[m_cnt];
        m_sor = s_sor[m_cnt]; m_rrb = s_rrb[m_cnt];
      end
    end else if (ro && m_sor != 0) begin
      m_rrb = (m_rrb == 0) ? m_sor - 1 : m_rrb - 1;
    end
    @(posedge clk); #1;
    alloc_valid = 0; call_valid = 0; ret_valid = 0; rotate = 0;
    chk_flags(eo, eu, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11 reset state
    chk_flags(0, 0, "R11");
    drive_map(5, 5, 0, "R1");
    drive_map(32, 0, 1, "R11");
    drive_map(127, 0, 1, "R11");
    probe("R11");

    // R4 allocate, R2 and R3 mapping
    do_op(1, 20, 12, 8, 0, 0, 0, "R4");
    drive_map(45, 45, 0, "R2");
    drive_map(51, 51, 0, "R2");
    drive_map(52, 0, 1, "R3");
    probe("R2 R3");

    // R9 rotation: base 0 -> 7 -> 6
    do_op(0, 0, 0, 0, 0, 0, 1, "R9");
    do_op(0, 0, 0, 0, 0, 0, 1, "R9");
    drive_map(32, 38, 0, "R9");
    drive_map(39, 37, 0, "R9");
    drive_map(40, 40, 0, "R9");
    probe("R9");

    // R5 call: caller outputs become callee bottom
    do_op(0, 0, 0, 0, 1, 0, 0, "R5");
    drive_map(32, 44, 0, "R5");
    drive_map(39, 51, 0, "R5");
    drive_map(40, 0, 1, "R5");
    drive_map(7, 7, 0, "R1");
    probe("R5");

    // R2 wraparound with full-size callee frame
    do_op(1, 96, 90, 0, 0, 0, 0, "R4");
    drive_map(127, 43, 0, "R2");
    probe("R2");

    // R4 refused allocates leave state unchanged
    do_op(1, 97, 0, 0, 0, 0, 0, "R4");
    do_op(1, 96, 10, 12, 0, 0, 0, "R4");
    do_op(1, 40, 50, 0, 0, 0, 0, "R4");
    drive_map(127, 43, 0, "R4");
    probe("R4");

    // R6 return restores caller frame incl. rotation base
    do_op(0, 0, 0, 0, 0, 1, 0, "R6");
    drive_map(32, 38, 0, "R6");
    drive_map(52, 0, 1, "R6");
    probe("R6");

    // R8 return on empty stack
    do_op(0, 0, 0, 0, 0, 1, 0, "R8");
    drive_map(32, 38, 0, "R8");
    probe("R8");

    // R10 ret beats rotate (ret underflows, rotate ignored)
    do_op(0, 0, 0, 0, 0, 0, 1, "R9");
    drive_map(32, 37, 0, "R9");
    do_op(0, 0, 0, 0, 0, 1, 1, "R10");
    drive_map(32, 37, 0, "R10");
    // R10 alloc beats call: no frame saved afterwards
    do_op(1, 24, 8, 8, 1, 0, 0, "R10");
    drive_map(32, 32, 0, "R10");
    do_op(0, 0, 0, 0, 0, 1, 0, "R10");
    probe("R10");

    // R7 fill the save stack, then overflow
    for (int i = 0; i < 8; i++) begin
      do_op(1, 16, 4, 0, 0, 0, 0, "R4");
      do_op(0, 0, 0, 0, 1, 0, 0, "R5");
    end
    drive_map(32, 64, 0, "R5");
    do_op(1, 16, 4, 0, 0, 0, 0, "R4");
    do_op(0, 0, 0, 0, 1, 0, 0, "R7");
    drive_map(44, 76, 0, "R7");
    probe("R7");
    for (int i = 0; i < 8; i++) do_op(0, 0, 0, 0, 0, 1, 0, "R6");
    probe("R6");
    do_op(0, 0, 0, 0, 0, 1, 0, "R8");

    // R10 call beats ret
    do_op(0, 0, 0, 0, 1, 1, 0, "R10");
    do_op(0, 0, 0, 0, 0, 1, 0, "R10");
    do_op(0, 0, 0, 0, 0, 1, 0, "R10");
    probe("R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule